// File: doc/BRIEF.md
# Multiplexed Auto-Increment Read-Only Byte Store

This block is one slow, byte-wide read-only store that shares a single 8-bit path for addresses and data. A host first sends a 16-bit address as two byte writes in counter mode. It then reads bytes in data mode. After each data access an internal counter moves forward, so the host can stream consecutive bytes without sending the address again. The host can also read the counter back in counter mode. It then receives the counter value plus one, one byte per access.

The top three address bits form a device identity. Several copies of this block can sit on one bus, each built with its own `DEV_ID`. All copies take every address load, answer every counter read and advance on every data access. Only the copy whose identity matches the current address drives data onto the bus. Every access is framed by an active-low select. After select is sampled low, `ready` rises only after a fixed number of clock cycles. The bidirectional bus is split into an input byte, an output byte and an output enable.

Top module: `grom_device`

## Requirements
- R1: After reset, `ready` and `bus_oe` are low, the counter is 0x0000 and the next counter byte is the low byte. The first counter read after reset therefore returns 0x01.
- R2: `ready` first reads high after exactly `WAIT_CYC`+1 rising edges that sample `sel_n` low. It stays high while `sel_n` stays low. It is low again one edge after `sel_n` is sampled high, and `bus_oe` is then low too.
- R3: A counter-mode write (`mode_addr`=1, `dir_rd`=0) loads `bus_i` into the low counter byte when the byte toggle expects the low byte. Otherwise it loads the high counter byte. Each such write flips the toggle.
- R4: A counter-mode read (`mode_addr`=1, `dir_rd`=1) returns byte 0 of (counter+1) modulo 2^16 when the toggle expects the low byte, and byte 1 otherwise. Each such read flips the toggle.
- R5: Any data-mode access (`mode_addr`=0), read or write, returns the toggle to expecting the low byte.
- R6: A data read at offset o (counter bits 12:0) returns o[7:0] XOR {o[12:8], o[12:10]} when o < `DEPTH` (default 0x1800). It returns 0x00 for o from `DEPTH` to 0x1FFF.
- R7: Every data access advances the offset. When the offset is `DEPTH`-1 or above, the next offset is 0; otherwise it is o+1. Counter bits 15:13 never change on a data access.
- R8: Data writes leave the stored bytes unchanged and never drive the bus.
- R9: A data read drives the bus only when counter bits 15:13 equal `DEV_ID`. Without a match, `bus_oe` stays low and the counter still advances. Counter loads and counter reads work whatever the identity bits hold.
- R10: During a responding read, `bus_oe` is high exactly while `ready` is high, and `bus_o` holds the byte captured for that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low select framing one access |
| dir_rd | input | 1 | 1 = read, 0 = write |
| mode_addr | input | 1 | 1 = counter access, 0 = data access |
| bus_i | input | 8 | Byte driven by the host |
| bus_o | output | 8 | Byte returned to the host |
| bus_oe | output | 1 | Output driver enable for `bus_o` |
| ready | output | 1 | High once the access is serviced |

## Verification
An access takes effect on the rising edge that is `WAIT_CYC`+1 edges after select is first sampled low. On that same edge `ready` rises and the captured read byte, the counter update and the toggle update all become visible. The bench counts edges from the negedge on which it lowers select, and samples `ready`, `bus_o` and `bus_oe` at the first negedge where `ready` is high. It then checks that the edge count equals `WAIT_CYC`+1. It raises select and checks `ready` and `bus_oe` one edge later. Counter state is observed only through later counter reads, with a bench model of counter and toggle giving the expected values.

// File: rtl/grom_pkg.sv
package grom_pkg;

    localparam int ADDR_W = 16;
    localparam int OFF_W  = 13;
    localparam int ID_W   = 3;

    typedef enum logic [1:0] {
        TM_IDLE,
        TM_WAIT,
        TM_HOLD
    } tm_state_e;

    typedef enum logic [1:0] {
        OP_ADDR_WR,
        OP_ADDR_RD,
        OP_DATA_WR,
        OP_DATA_RD
    } op_e;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [OFF_W-1:0] off;
    } gaddr_t;

    function automatic op_e decode_op(input logic mode_addr, input logic dir_rd);
        if (mode_addr) return dir_rd ? OP_ADDR_RD : OP_ADDR_WR;
        return dir_rd ? OP_DATA_RD : OP_DATA_WR;
    endfunction

    function automatic logic is_data_op(input op_e op);
        return (op == OP_DATA_WR) || (op == OP_DATA_RD);
    endfunction

    // Offset step with wrap at the end of the populated range.
    function automatic logic [OFF_W-1:0] step_off(input logic [OFF_W-1:0] off,
                                                  input logic [OFF_W:0]   depth);
        if ({1'b0, off} >= (depth - 1'b1)) return '0;
        return off + 1'b1;
    endfunction

    // Stored contents, defined by formula so no table is needed.
    function automatic logic [7:0] stored_byte(input logic [OFF_W-1:0] off,
                                               input logic [OFF_W:0]   depth);
        if ({1'b0, off} >= depth) return 8'h00;
        return off[7:0] ^ {off[12:8], off[12:10]};
    endfunction

endpackage

// File: rtl/grom_wait_timer.sv
module grom_wait_timer
    import grom_pkg::*;
#(
    parameter int WAIT_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_n,
    output logic fire,
    output logic ready
);
    localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);
    localparam int RW = $clog2(WAIT_CYC + 2) + 1;
    localparam logic [RW-1:0] RUN_MAX = '1;
    localparam logic [RW-1:0] RUN_AT_RISE = RW'(WAIT_CYC + 1);

    tm_state_e st_q;
    logic [CW-1:0] cnt_q;

    assign fire = (st_q == TM_WAIT) && !sel_n && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TM_IDLE;
            cnt_q <= '0;
            ready <= 1'b0;
        end else begin
            case (st_q)
                TM_IDLE: begin
                    if (!sel_n) begin
                        st_q  <= TM_WAIT;
                        cnt_q <= '0;
                    end
                end
                TM_WAIT: begin
                    if (sel_n) begin
                        st_q <= TM_IDLE;
                    end else if (fire) begin
                        st_q  <= TM_HOLD;
                        ready <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                TM_HOLD: begin
                    if (sel_n) begin
                        st_q  <= TM_IDLE;
                        ready <= 1'b0;
                    end
                end
                default: st_q <= TM_IDLE;
            endcase
        end
    end

    // Run length of select held low, used only to check the wait window.
    logic [RW-1:0] low_run_q;
    always_ff @(posedge clk) begin
        if (rst)                    low_run_q <= '0;
        else if (sel_n)             low_run_q <= '0;
        else if (low_run_q != RUN_MAX) low_run_q <= low_run_q + 1'b1;
    end

    p_ready_delay_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (low_run_q == RUN_AT_RISE));

    p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> !ready);

    p_fire_not_ready_r2: assert property (@(posedge clk) disable iff (rst)
        fire |-> !ready);

endmodule

// File: rtl/grom_addr_ctr.sv
module grom_addr_ctr
    import grom_pkg::*;
#(
    parameter int DEPTH = 6144
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  op_e        op,
    input  logic [7:0] wbyte,
    output gaddr_t     addr,
    output logic       hi_next
);
    localparam logic [OFF_W:0] DEPTH_L = DEPTH[OFF_W:0];

    logic [ADDR_W-1:0] cnt_q;
    assign addr = gaddr_t'(cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            hi_next <= 1'b0;
        end else if (fire) begin
            case (op)
                OP_ADDR_WR: begin
                    if (hi_next) cnt_q[15:8] <= wbyte;
                    else         cnt_q[7:0]  <= wbyte;
                    hi_next <= !hi_next;
                end
                OP_ADDR_RD: begin
                    hi_next <= !hi_next;
                end
                default: begin
                    cnt_q[OFF_W-1:0] <= step_off(cnt_q[OFF_W-1:0], DEPTH_L);
                    hi_next          <= 1'b0;
                end
            endcase
        end
    end

    p_low_load_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && op == OP_ADDR_WR && !hi_next) |=> (cnt_q[7:0] == $past(wbyte)));

    p_high_load_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && op == OP_ADDR_WR && hi_next) |=> (cnt_q[15:8] == $past(wbyte)));

    p_toggle_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (fire && is_data_op(op)) |=> !hi_next);

    p_id_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && is_data_op(op)) |=> $stable(addr.id));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(cnt_q));

endmodule

// File: rtl/grom_content.sv
module grom_content
    import grom_pkg::*;
#(
    parameter int DEPTH = 6144
) (
    input  logic [OFF_W-1:0] off,
    output logic [7:0]       data
);
    localparam logic [OFF_W:0] DEPTH_L = DEPTH[OFF_W:0];

    assign data = stored_byte(off, DEPTH_L);

    always_comb begin
        if ({1'b0, off} >= DEPTH_L)
            a_gap_zero_r6: assert (data == 8'h00);
    end

endmodule

// File: rtl/grom_device.sv
module grom_device
    import grom_pkg::*;
#(
    parameter int DEV_ID   = 2,
    parameter int DEPTH    = 6144,
    parameter int WAIT_CYC = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_n,
    input  logic       dir_rd,
    input  logic       mode_addr,
    input  logic [7:0] bus_i,
    output logic [7:0] bus_o,
    output logic       bus_oe,
    output logic       ready
);
    localparam logic [ID_W-1:0] MY_ID = DEV_ID[ID_W-1:0];

    op_e               op;
    logic              fire;
    gaddr_t            addr;
    logic              hi_next;
    logic [7:0]        rom_byte;
    logic [ADDR_W-1:0] plus1;
    logic              id_hit;
    logic [7:0]        rd_byte;
    logic              responds;
    logic [7:0]        dout_q;
    logic              drive_q;

    assign op = decode_op(mode_addr, dir_rd);

    grom_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .sel_n (sel_n),
        .fire  (fire),
        .ready (ready)
    );

    grom_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .op      (op),
        .wbyte   (bus_i),
        .addr    (addr),
        .hi_next (hi_next)
    );

    grom_content #(.DEPTH(DEPTH)) u_rom (
        .off  (addr.off),
        .data (rom_byte)
    );

    assign plus1  = addr + 1'b1;
    assign id_hit = (addr.id == MY_ID);

    always_comb begin
        rd_byte  = 8'h00;
        responds = 1'b0;
        case (op)
            OP_ADDR_RD: begin
                rd_byte  = hi_next ? plus1[15:8] : plus1[7:0];
                responds = 1'b1;
            end
            OP_DATA_RD: begin
                rd_byte  = rom_byte;
                responds = id_hit;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q  <= 8'h00;
            drive_q <= 1'b0;
        end else if (fire) begin
            dout_q  <= rd_byte;
            drive_q <= responds;
        end else if (sel_n) begin
            drive_q <= 1'b0;
        end
    end

    assign bus_o  = dout_q;
    assign bus_oe = drive_q && ready;

    p_miss_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (fire && op == OP_DATA_RD && !id_hit) |=> !bus_oe);

    p_write_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (fire && !dir_rd) |=> !bus_oe);

    p_addr_read_drives_r10: assert property (@(posedge clk) disable iff (rst)
        (fire && op == OP_ADDR_RD) |=> bus_oe);

    p_hold_byte_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_o));

endmodule

// File: tb/test_grom_device.sv
`timescale 1ns/1ps
module test_grom_device;
    localparam int DEV_ID   = 2;
    localparam int DEPTH    = 6144;
    localparam int WAIT_CYC = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1;
    logic       dir_rd = 1'b0;
    logic       mode_addr = 1'b0;
    logic [7:0] bus_i = 8'h00;
    logic [7:0] bus_o;
    logic       bus_oe;
    logic       ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] mc = 16'h0000;
    logic        mf = 1'b0;

    always #4 clk = ~clk;

    grom_device #(.DEV_ID(DEV_ID), .DEPTH(DEPTH), .WAIT_CYC(WAIT_CYC)) i_grom_device (
        .clk(clk), .rst(rst), .sel_n(sel_n), .dir_rd(dir_rd), .mode_addr(mode_addr),
        .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe), .ready(ready)
    );

    function automatic logic [7:0] exp_rom(input logic [12:0] o);
        if (o >= 13'(DEPTH)) return 8'h00;
        return o[7:0] ^ {o[12:8], o[12:10]};
    endfunction

    function automatic logic [12:0] exp_step(input logic [12:0] o);
        if (o >= 13'(DEPTH - 1)) return 13'h0;
        return o + 13'h1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_access(input logic m, input logic rd, input logic [7:0] wb,
                             output logic [7:0] rb, output logic oe);
        int n;
        @(negedge clk);
        mode_addr = m; dir_rd = rd; bus_i = wb; sel_n = 1'b0;
        n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (!ready && n < 64);
        chk(n == WAIT_CYC + 1, "R2 ready delay", n, WAIT_CYC + 1);
        rb = bus_o; oe = bus_oe;
        sel_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(!ready && !bus_oe, "R2 release", {ready, bus_oe}, 0);
    endtask

    task automatic op_awr(input logic [7:0] b);
        logic [7:0] rb; logic oe;
        do_access(1'b1, 1'b0, b, rb, oe);
        chk(!oe, "R3 counter write drives no bus", oe, 0);
        if (!mf) mc[7:0] = b; else mc[15:8] = b;
        mf = !mf;
    endtask

    task automatic op_ard(input string tag);
        logic [7:0] rb; logic oe; logic [15:0] p; logic [7:0] e;
        p = mc + 16'h1;
        e = mf ? p[15:8] : p[7:0];
        do_access(1'b1, 1'b1, 8'h00, rb, oe);
        chk(rb == e, tag, rb, e);
        chk(oe, "R10 counter read drives", oe, 1);
        mf = !mf;
    endtask

    task automatic op_dwr(input logic [7:0] b);
        logic [7:0] rb; logic oe;
        do_access(1'b0, 1'b0, b, rb, oe);
        chk(!oe, "R8 data write drives no bus", oe, 0);
        mc[12:0] = exp_step(mc[12:0]);
        mf = 1'b0;
    endtask

    task automatic op_drd(input string tag);
        logic [7:0] rb; logic oe; logic hit; logic [7:0] e;
        hit = (mc[15:13] == 3'(DEV_ID));
        e = exp_rom(mc[12:0]);
        do_access(1'b0, 1'b1, 8'h00, rb, oe);
        chk(oe == hit, "R9 id gating", oe, hit);
        if (hit) chk(rb == e, tag, rb, e);
        mc[12:0] = exp_step(mc[12:0]);
        mf = 1'b0;
    endtask

    task automatic sync_low();
        if (mf) op_ard("R4 realign read");
    endtask

    task automatic load16(input logic [15:0] a);
        sync_low();
        op_awr(a[7:0]);
        op_awr(a[15:8]);
    endtask

    task automatic readback(input string tag);
        sync_low();
        op_ard(tag);
        op_ard(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7071));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(!ready && !bus_oe, "R1 reset outputs", {ready, bus_oe}, 0);
        op_ard("R1 first counter read");           // expects 0x01
        op_ard("R1 high byte after reset");        // expects 0x00

        load16(16'h4123);
        readback("R3 R4 load then read back");
        op_drd("R6 data read");
        op_drd("R6 streamed read");
        readback("R7 advance after reads");

        load16(16'h57FE);
        op_drd("R6 read near top");
        op_drd("R6 read top byte");
        readback("R7 wrap to zero keeps id");

        load16(16'h5900);
        op_drd("R6 gap reads zero");
        load16(16'h5FFF);
        op_drd("R6 gap top reads zero");
        readback("R7 wrap from gap");

        load16(16'h4010);
        op_dwr(8'h5A);
        readback("R7 advance after write");
        load16(16'h4010);
        op_drd("R8 contents unchanged after write");

        load16(16'h2005);
        op_drd("R9 mismatch");
        readback("R9 counter advances on mismatch");

        sync_low();
        op_awr(8'h34);
        op_drd("R5 data access mid-load");
        op_awr(8'h10);
        op_awr(8'h40);
        readback("R5 toggle cleared by data access");

        for (int i = 0; i < 300; i++) begin
            int k;
            k = int'($urandom % 8);
            case (k)
                0, 1: op_awr((mf && ($urandom % 4 != 0)) ?
                             {3'(DEV_ID), 5'($urandom)} : 8'($urandom));
                2:    op_ard("R4 random counter read");
                3:    op_dwr(8'($urandom));
                default: op_drd("R6 random data read");
            endcase
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule